// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-mapped watchdog for a system-on-chip. A programmable prescaler and a selectable power-of-two divider turn the system clock into a slow tick. Each tick counts a down-counter towards zero. When the count runs out, the block fires the actions that software enabled: a one-cycle interrupt pulse, a system reset request held for a fixed number of clocks, or both. The counter then restarts from a separate reload value.

Software keeps the system alive by writing a fresh value into the live count register before the count runs out. That write also restarts the tick chain, so a full tick period always follows it. Three word registers hold the state: control, reload value and live count. The block leaves reset already running, with the reset action armed, so a system that never services it is restarted.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the control register reads 0x8021, and both the reload and live count registers read 0x8000.
- R2: Word offset 0x0 is control, 0x4 is reload and 0x8 is live count. Control bit 0 arms the reset action, bit 2 arms the interrupt, bits [4:3] pick the divider, bit 5 runs the timer and bits [15:8] hold the prescale value. All other control bits read as zero.
- R3: While running, a tick occurs once every (prescale+1) x (16 << divider select) clocks. Divider select 0,1,2,3 gives 16,32,64,128, and the prescale value ranges over 0..255.
- R4: A tick on a count of 2 or more decrements it. A tick on a count of 1 is an expiry, and the counter is then loaded from the reload register. A count of N (N >= 1) therefore expires on its Nth tick, and later expiries follow every reload-value ticks.
- R5: When the interrupt is armed, each expiry gives exactly one clock of interrupt high. The pulse starts in the clock after the tick. With the interrupt not armed there is none.
- R6: When the reset action is armed, each expiry drives the reset output high for exactly 4 clocks, starting in the clock after the tick. With the reset action not armed it stays low.
- R7: Writing the live count register loads it at once and restarts the prescaler and divider. The next tick is then a full period after the write.
- R8: With the run bit clear, the count holds its value and neither output is raised. Setting the run bit again starts a full tick period.
- R9: The live count register reads the current counter value as it decrements.
- R10: A live count of 0 expires on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data; bits [15:0] are used |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | 1 | One-clock expiry interrupt pulse |
| sys_reset_o | output | 1 | Expiry reset request, high for 4 clocks |

## Verification
The bench sweeps every divider select against several prescale values, plus the largest prescale with the largest divider. It times both the first expiry and the reload interval, so a divider picking the wrong power of two or a prescaler off by one shows up as a wrong interval. It services the counter mid-period; a design that leaves the prescale chain running would expire a partial period early. It also stops the timer part-way and starts it again; a design that keeps counting, or resumes a stale period, would shift the expiry. The count-zero case and the exact four-clock reset width are checked, since an off-by-one in the expiry compare or the hold counter changes the observed cycle counts.

// File: rtl/twd_pkg.sv
package twd_pkg;

  localparam int PS_W   = 8;
  localparam int DSEL_W = 2;
  localparam int REG_W  = 16;

  localparam logic [1:0] SLOT_CTRL   = 2'd0;
  localparam logic [1:0] SLOT_RELOAD = 2'd1;
  localparam logic [1:0] SLOT_COUNT  = 2'd2;

  typedef struct packed {
    logic [PS_W-1:0]   ps;
    logic [DSEL_W-1:0] dsel;
    logic              run;
    logic              irq_en;
    logic              rst_en;
  } twd_ctrl_t;

  // control word layout: [15:8] prescale, [5] run, [4:3] divider, [2] irq, [0] reset
  function automatic logic [REG_W-1:0] ctrl_to_word(twd_ctrl_t c);
    logic [REG_W-1:0] w;
    w        = '0;
    w[15:8]  = c.ps;
    w[5]     = c.run;
    w[4:3]   = c.dsel;
    w[2]     = c.irq_en;
    w[0]     = c.rst_en;
    return w;
  endfunction

  function automatic twd_ctrl_t word_to_ctrl(logic [REG_W-1:0] w);
    twd_ctrl_t c;
    c.ps     = w[15:8];
    c.run    = w[5];
    c.dsel   = w[4:3];
    c.irq_en = w[2];
    c.rst_en = w[0];
    return c;
  endfunction

  function automatic int unsigned div_len(logic [DSEL_W-1:0] sel, int unsigned base_log2);
    return 32'd1 << (base_log2 + int'(sel));
  endfunction

  function automatic int unsigned tick_period(logic [PS_W-1:0] ps, logic [DSEL_W-1:0] sel,
                                              int unsigned base_log2);
    return (int'(ps) + 1) * div_len(sel, base_log2);
  endfunction

endpackage

// File: rtl/twd_regs.sv
module twd_regs
  import twd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter logic [REG_W-1:0] CTRL_INIT   = 16'h8021,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output twd_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic [DATA_W-1:0] bus_rdata
);

  logic [1:0]  slot;
  logic        hi_zero;
  logic        wr_en;
  logic        unused_bits;

  assign slot        = bus_addr[3:2];
  assign hi_zero     = (bus_addr >> 4) == '0;
  assign wr_en       = bus_sel && bus_wr && hi_zero;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:REG_W]};

  assign cnt_load     = wr_en && (slot == SLOT_COUNT);
  assign cnt_load_val = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= word_to_ctrl(CTRL_INIT);
      reload <= RELOAD_INIT;
    end else if (wr_en) begin
      if (slot == SLOT_CTRL)   ctrl   <= word_to_ctrl(bus_wdata[REG_W-1:0]);
      if (slot == SLOT_RELOAD) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hi_zero) begin
      case (slot)
        SLOT_CTRL:   bus_rdata = DATA_W'(ctrl_to_word(ctrl));
        SLOT_RELOAD: bus_rdata = DATA_W'(reload);
        SLOT_COUNT:  bus_rdata = DATA_W'(live_cnt);
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R2: a control write lands in the register one edge later
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && slot == SLOT_CTRL) |=> ctrl_to_word(ctrl) == ($past(bus_wdata[REG_W-1:0]) & 16'hFF3D));

endmodule

// File: rtl/twd_prescale.sv
module twd_prescale
  import twd_pkg::*;
#(
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [PS_W-1:0]   ps,
  input  logic [DSEL_W-1:0] dsel,
  output logic              tick
);

  localparam int DW = DIV_BASE_LOG2 + (1 << DSEL_W) - 1;

  logic [PS_W-1:0] pcnt;
  logic [DW-1:0]   dcnt;
  logic [DW-1:0]   dlast;
  logic            pwrap;

  assign pwrap = run && (pcnt >= ps);
  assign dlast = DW'(div_len(dsel, DIV_BASE_LOG2) - 1);
  assign tick  = pwrap && (dcnt >= dlast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (!run || restart) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (pwrap) begin
      pcnt <= '0;
      if (tick) dcnt <= '0;
      else      dcnt <= dcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // R7: a restart leaves no tick in the following clock
  p_restart_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  // R3: ticks are never back to back
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/twd_core.sv
module twd_core #(
  parameter int CNT_W    = 16,
  parameter int RST_HOLD = 4,
  parameter logic [CNT_W-1:0] CNT_INIT = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             rst_en,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             irq_o,
  output logic             sys_reset_o
);

  localparam int HW = $clog2(RST_HOLD + 1);

  logic [HW-1:0] hold;

  assign expire      = tick && (cnt <= CNT_W'(1));
  assign sys_reset_o = hold != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= CNT_INIT;
    else if (load)     cnt <= load_val;
    else if (expire)   cnt <= reload;
    else if (tick)     cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= expire && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hold <= '0;
    else if (!rst_en)      hold <= '0;
    else if (expire)       hold <= HW'(RST_HOLD);
    else if (hold != '0)   hold <= hold - 1'b1;
  end

  // R5: interrupt is one clock wide
  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R6: the reset output only starts after an armed expiry
  p_rst_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_o) |-> ($past(expire) && $past(rst_en)));

  // R4: a plain tick steps the count down by one
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt > CNT_W'(1)) |=> cnt == $past(cnt) - 1'b1);

  // R4: an expiry takes the reload value
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> cnt == $past(reload));

  // R7: a bus load wins over everything else
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import twd_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int CNT_W         = 16,
  parameter int DIV_BASE_LOG2 = 4,
  parameter int RST_HOLD      = 4,
  parameter logic [REG_W-1:0] CTRL_INIT  = 16'h8021,
  parameter logic [CNT_W-1:0] CNT_INIT   = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_reset_o
);

  twd_ctrl_t        ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] cnt_load_val;
  logic             cnt_load;
  logic             tick;
  logic             expire;

  twd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CTRL_INIT(CTRL_INIT), .RELOAD_INIT(CNT_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .live_cnt(live_cnt), .ctrl(ctrl), .reload(reload),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .bus_rdata(bus_rdata)
  );

  twd_prescale #(.DIV_BASE_LOG2(DIV_BASE_LOG2)) u_prescale (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(cnt_load),
    .ps(ctrl.ps), .dsel(ctrl.dsel), .tick(tick)
  );

  twd_core #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD), .CNT_INIT(CNT_INIT)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load), .load_val(cnt_load_val),
    .reload(reload), .irq_en(ctrl.irq_en), .rst_en(ctrl.rst_en),
    .cnt(live_cnt), .expire(expire), .irq_o(irq_o), .sys_reset_o(sys_reset_o)
  );

  // R8: a stopped timer holds its count
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !cnt_load) |=> $stable(live_cnt));

  // R8: a stopped timer never expires
  p_no_expire_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |-> !expire);

endmodule

// File: tb/tb_tick_watchdog.sv
`timescale 1ns/1ps
module tb_tick_watchdog;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        sys_reset_o;

  int nchk = 0;
  int nerr = 0;
  int irq_seen = 0;
  int rst_seen = 0;

  always #4 clk = ~clk;

  tick_watchdog dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_reset_o(sys_reset_o)
  );

  always @(negedge clk) begin
    if (irq_o) irq_seen++;
    if (sys_reset_o) rst_seen++;
  end

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write edge is the next posedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int period(int ps, int sel);
    return (ps + 1) * (16 << sel);
  endfunction

  function automatic logic [31:0] ctrl_word(int ps, int sel, bit run, bit ie, bit re);
    return (32'(ps) << 8) | (32'(run) << 5) | (32'(sel) << 3) | (32'(ie) << 2) | 32'(re);
  endfunction

  task automatic wait_irq(inout int n, input int limit);
    while (!irq_o && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic wait_rst(inout int n, input int limit);
    while (!sys_reset_o && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic arm(input int ps, input int sel, input int cnt, input int rel,
                     input bit ie, input bit re);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'(rel));
    wr(4'h8, 32'(cnt));
    wr(4'h0, ctrl_word(ps, sel, 1'b1, ie, re));
  endtask

  initial begin
    #(200000 * 8);
    nerr++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, n1, hi, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(4'h0, d); check("R1 ctrl", d, 32'h8021);
    rd(4'h4, d); check("R1 reload", d, 32'h8000);
    rd(4'h8, d); check("R1 count", d, 32'h8000);
    @(negedge clk);

    // R2 layout, reserved bits, independent registers
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R2 ctrl mask", d, 32'hFF3D);
    @(negedge clk);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h1234);
    wr(4'h8, 32'h0ABC);
    rd(4'h4, d); check("R2 reload", d, 32'h1234);
    rd(4'h8, d); check("R2 count", d, 32'h0ABC);
    @(negedge clk);

    // R3 R4 R5 sweep: count 2, reload 1, interrupt only
    for (int ps = 0; ps < 4; ps++) begin
      for (int sel = 0; sel < 4; sel++) begin
        p = period(ps, sel);
        irq_seen = 0; rst_seen = 0;
        arm(ps, sel, 2, 1, 1'b1, 1'b0);
        n = 1; wait_irq(n, 4 * p + 10);
        check("R3 R4 first expiry", n, 2 * p + 1);
        n1 = n;
        @(negedge clk); n++;
        check("R5 pulse width", irq_o, 0);
        wait_irq(n, n1 + 2 * p + 10);
        check("R4 reload interval", n - n1, p);
        check("R6 no reset unarmed", rst_seen, 0);
        @(negedge clk);
      end
    end

    // R3 largest prescale and divider
    arm(255, 3, 1, 1000, 1'b1, 1'b0);
    n = 1; wait_irq(n, 40000);
    check("R3 max period", n, period(255, 3) + 1);
    @(negedge clk);

    // R6 reset only, four clocks
    irq_seen = 0;
    arm(0, 0, 1, 1000, 1'b0, 1'b1);
    n = 1; wait_rst(n, 100);
    check("R6 reset start", n, 17);
    hi = 0;
    while (sys_reset_o && hi < 20) begin hi++; @(negedge clk); end
    check("R6 reset width", hi, 4);
    check("R5 no irq unarmed", irq_seen, 0);

    // R5 R6 both armed, same clock
    arm(0, 0, 1, 1000, 1'b1, 1'b1);
    n = 1; wait_irq(n, 100);
    check("R5 irq both", n, 17);
    check("R6 reset both", sys_reset_o, 1);
    @(negedge clk);

    // R9 live count readback
    arm(0, 0, 5, 5, 1'b0, 1'b0);
    repeat (16) @(negedge clk);
    rd(4'h8, d); check("R9 count after one tick", d, 4);
    @(negedge clk);

    // R7 servicing restarts the full period
    arm(0, 0, 3, 3, 1'b1, 1'b0);
    irq_seen = 0;
    repeat (39) @(negedge clk);
    check("R7 no early expiry", irq_seen, 0);
    wr(4'h8, 32'd3);
    n = 1; wait_irq(n, 200);
    check("R7 service period", n, 49);
    @(negedge clk);

    // R8 stop holds count, no outputs; restart full period
    arm(0, 0, 2, 2, 1'b1, 1'b1);
    repeat (19) @(negedge clk);
    wr(4'h0, 32'h0);
    irq_seen = 0; rst_seen = 0;
    repeat (100) @(negedge clk);
    check("R8 no irq stopped", irq_seen, 0);
    check("R8 no reset stopped", rst_seen, 0);
    rd(4'h8, d); check("R8 count held", d, 1);
    @(negedge clk);
    wr(4'h0, ctrl_word(0, 0, 1'b1, 1'b1, 1'b0));
    n = 1; wait_irq(n, 100);
    check("R8 restart full period", n, 17);
    @(negedge clk);

    // R10 count zero expires on first tick
    arm(1, 1, 0, 5, 1'b1, 1'b0);
    n = 1; wait_irq(n, 300);
    check("R10 zero count", n, period(1, 1) + 1);
    @(negedge clk);
    wr(4'h0, 32'h0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule